// File: doc/BRIEF.md
# VCO Coarse Band Calibration Controller

This controller picks the coarse tuning band of a voltage-controlled oscillator while the phase-locked loop stays closed. Two window comparators watch the loop's control voltage. One flag reports that the voltage is below the lower threshold, and the other reports that it is above the upper threshold. When one of these flags holds steadily for a programmed dwell time, the PLL is taken to be unable to lock in the current band. A slow step tick, derived from the reference clock by a programmable divider, then moves a band counter one code per tick. The controller stops moving the counter once the voltage settles inside the window.

The band counter starts at mid-range after reset and saturates at both ends. Its value is decoded into a thermometer word that drives equal unit capacitors, so each step switches exactly one unit. The `locked_o` flag reports a sustained in-window condition. The `cal_fail_o` flag reports that the search is pressing against an end of the band range. All pins are plain control and status levels. There is no data stream, so no valid/ready handshake and no back-pressure applies.

Top module: `vco_band_cal`

## Requirements
- R1: During reset and immediately after it, the band counter holds NUM_UNITS/2 = 8. `cap_therm_o` then reads 16'h00FF, and `locked_o` and `cal_fail_o` are 0.
- R2: Both comparator flags pass through a two-flop synchronizer before use. The synchronized pair {above, below} is decoded as follows: 00 means inside the window, 01 means below, 10 means above, 11 means invalid.
- R3: A condition counts as qualified only after the synchronized pair has stayed unchanged for `dwell_i`+1 consecutive cycles. Any change of the pair restarts this count, so a shorter excursion outside the window leaves the band untouched.
- R4: On each step tick while "below" is qualified, the band rises by exactly one and one more unit capacitor is switched in. On each step tick while "above" is qualified, the band falls by exactly one.
- R5: Step ticks occur once every `step_div_i`+1 reference cycles. Consecutive steps of one uninterrupted search are therefore spaced exactly that far apart.
- R6: The band saturates at 0 and at NUM_UNITS (16) and never wraps.
- R7: `cal_fail_o` is 1 while the band is at 16 with "below" qualified, or at 0 with "above" qualified. It is 0 in every other case.
- R8: Bit i of `cap_therm_o` is 1 exactly when the band is greater than i. Any two consecutive words differ in at most one bit.
- R9: `locked_o` rises exactly `dwell_i`+4 rising edges after the comparator inputs enter the window, provided they stay there. While locked, `cap_therm_o` does not change.
- R10: The invalid pair (both flags set) causes no step and never yields `locked_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vc_below_i | input | 1 | Comparator flag: control voltage under lower threshold (asynchronous) |
| vc_above_i | input | 1 | Comparator flag: control voltage over upper threshold (asynchronous) |
| step_div_i | input | DIV_W (8) | Step tick period minus one, in reference cycles |
| dwell_i | input | PER_W (12) | Dwell time minus one, in reference cycles |
| cap_therm_o | output | NUM_UNITS (16) | Thermometer-coded unit capacitor enables |
| locked_o | output | 1 | Sustained in-window indication |
| cal_fail_o | output | 1 | Search pinned at an end of the band range |

## Verification
A corrupted band register shows up at `cap_therm_o` in the same cycle, as a wrong unit count or a word that is not a thermometer code. The scoreboard compares every such change against the expected band sequence. A dwell counter that restarts at the wrong moment shifts the rise of `locked_o` away from its exact cycle, or lets a short glitch move the band. Both effects appear within `dwell_i`+4 cycles of the input change. A faulty step divider alters the spacing between successive band changes, and this spacing is measured on every change after the first in each search.

// File: rtl/vcal_pkg.sv
package vcal_pkg;
  // Synchronized comparator pair: bit1 = above upper threshold, bit0 = below lower threshold
  typedef enum logic [1:0] {
    WIN_IN    = 2'b00,
    WIN_BELOW = 2'b01,
    WIN_ABOVE = 2'b10,
    WIN_BAD   = 2'b11
  } win_e;
endpackage

// File: rtl/vcal_sync.sv
module vcal_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/vcal_stepgen.sv
module vcal_stepgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] dcnt_q;

  assign tick_o = (dcnt_q >= div_i);

  always_ff @(posedge clk) begin
    if (!rst_n)      dcnt_q <= '0;
    else if (tick_o) dcnt_q <= '0;
    else             dcnt_q <= dcnt_q + 1'b1;
  end

  // R5
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_i != '0) |=> (!tick_o || div_i == '0));
endmodule

// File: rtl/vcal_persist.sv
module vcal_persist
  import vcal_pkg::*;
#(
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  win_e             cond_i,
  input  logic [PER_W-1:0] dwell_i,
  output win_e             held_o,
  output logic             qual_o
);
  logic [PER_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_o <= WIN_IN;
      cnt_q  <= '0;
    end else begin
      held_o <= cond_i;
      if (cond_i != held_o)    cnt_q <= '0;
      else if (cnt_q < dwell_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign qual_o = (cnt_q >= dwell_i);

  // R3
  dwell_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(held_o) |-> (!qual_o || dwell_i == '0));
endmodule

// File: rtl/vcal_band.sv
module vcal_band #(
  parameter int NUM_UNITS = 16,
  parameter int BAND_W    = $clog2(NUM_UNITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inc_i,
  input  logic                 dec_i,
  output logic [BAND_W-1:0]    band_o,
  output logic [NUM_UNITS-1:0] therm_o
);
  localparam logic [BAND_W-1:0] BAND_MAX = BAND_W'(NUM_UNITS);
  localparam logic [BAND_W-1:0] BAND_MID = BAND_W'(NUM_UNITS / 2);

  always_ff @(posedge clk) begin
    if (!rst_n)                            band_o <= BAND_MID;
    else if (inc_i && band_o != BAND_MAX)  band_o <= band_o + 1'b1;
    else if (dec_i && band_o != '0)        band_o <= band_o - 1'b1;
  end

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
    assign therm_o[i] = (int'(band_o) > i);
  end

  // R6
  band_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    band_o <= BAND_MAX);

  // R4
  band_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(band_o) |-> (band_o == $past(band_o) + 1'b1 || band_o == $past(band_o) - 1'b1));
endmodule

// File: rtl/vco_band_cal.sv
module vco_band_cal
  import vcal_pkg::*;
#(
  parameter int NUM_UNITS = 16,
  parameter int DIV_W     = 8,
  parameter int PER_W     = 12
) (
  input  logic                 clk_ref,
  input  logic                 rst_n,
  input  logic                 vc_below_i,
  input  logic                 vc_above_i,
  input  logic [DIV_W-1:0]     step_div_i,
  input  logic [PER_W-1:0]     dwell_i,
  output logic [NUM_UNITS-1:0] cap_therm_o,
  output logic                 locked_o,
  output logic                 cal_fail_o
);
  localparam int BAND_W = $clog2(NUM_UNITS + 1);
  localparam logic [BAND_W-1:0] BAND_MAX = BAND_W'(NUM_UNITS);

  logic [1:0]        pair_s;
  win_e              held;
  logic              qual, tick;
  logic              inc, dec;
  logic [BAND_W-1:0] band;

  vcal_sync #(.W(2)) u_sync (
    .clk(clk_ref), .rst_n(rst_n),
    .d_i({vc_above_i, vc_below_i}), .q_o(pair_s)
  );

  vcal_persist #(.PER_W(PER_W)) u_persist (
    .clk(clk_ref), .rst_n(rst_n), .cond_i(win_e'(pair_s)),
    .dwell_i(dwell_i), .held_o(held), .qual_o(qual)
  );

  vcal_stepgen #(.DIV_W(DIV_W)) u_stepgen (
    .clk(clk_ref), .rst_n(rst_n), .div_i(step_div_i), .tick_o(tick)
  );

  assign inc = tick && qual && (held == WIN_BELOW);
  assign dec = tick && qual && (held == WIN_ABOVE);

  vcal_band #(.NUM_UNITS(NUM_UNITS), .BAND_W(BAND_W)) u_band (
    .clk(clk_ref), .rst_n(rst_n), .inc_i(inc), .dec_i(dec),
    .band_o(band), .therm_o(cap_therm_o)
  );

  always_ff @(posedge clk_ref) begin
    if (!rst_n) begin
      locked_o   <= 1'b0;
      cal_fail_o <= 1'b0;
    end else begin
      locked_o   <= qual && (held == WIN_IN);
      cal_fail_o <= qual && (((held == WIN_BELOW) && (band == BAND_MAX)) ||
                             ((held == WIN_ABOVE) && (band == '0)));
    end
  end

  // R8
  therm_one_bit_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $countones(cap_therm_o ^ $past(cap_therm_o)) <= 1);

  // R9
  lock_freeze_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (locked_o && $past(locked_o)) |-> $stable(cap_therm_o));

  // R3
  step_needs_dwell_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !$stable(band) |-> ($past(qual) && $past(tick)));

  // R7
  fail_at_limit_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    cal_fail_o |-> (cap_therm_o == '0 || &cap_therm_o));

  // R10
  bad_pair_no_lock_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (held == WIN_BAD) |=> !locked_o);
endmodule

// File: tb/vco_band_cal_bench.sv
module vco_band_cal_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        below = 1'b0, above = 1'b0;
  logic [7:0]  div_r = 8'd3;
  logic [11:0] dwell_r = 12'd20;
  logic [15:0] therm;
  logic        locked, fail;

  int checks = 0, failures = 0;
  int exp_q[$];
  int cyc = 0, last_chg = 0, exp_per = 0;
  bit first_chg = 1'b1, done = 1'b0;
  logic [15:0] prev_therm = 16'h00FF;

  always #4 clk = ~clk;

  vco_band_cal u_vco_band_cal (
    .clk_ref(clk), .rst_n(rst_n), .vc_below_i(below), .vc_above_i(above),
    .step_div_i(div_r), .dwell_i(dwell_r),
    .cap_therm_o(therm), .locked_o(locked), .cal_fail_o(fail)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic drive(input logic b, input logic a);
    @(negedge clk);
    below = b;
    above = a;
  endtask

  task automatic push_burst(input int from, input int to, input int period);
    first_chg = 1'b1;
    exp_per = period;
    if (to > from) for (int v = from + 1; v <= to; v++) exp_q.push_back(v);
    else           for (int v = from - 1; v >= to; v--) exp_q.push_back(v);
  endtask

  // Monitor: pops expected band values as the thermometer word changes
  initial begin
    forever begin
      @(posedge clk);
      #2;
      cyc++;
      if (rst_n && therm !== prev_therm) begin
        int n;
        n = $countones(therm);
        // R8: thermometer form, single bit change
        chk(therm == 16'((32'd1 << n) - 1), "R8 thermometer form", therm, 16'((32'd1 << n) - 1));
        chk($countones(therm ^ prev_therm) == 1, "R8 one unit per step", therm ^ prev_therm, 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6/R9 unexpected band change", n, -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(n == e, "R4 band sequence", n, e);
          if (!first_chg) chk(cyc - last_chg == exp_per, "R5 step spacing", cyc - last_chg, exp_per);
        end
        first_chg = 1'b0;
        last_chg = cyc;
        prev_therm = therm;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 during reset
    chk(therm == 16'h00FF, "R1 reset therm", therm, 16'h00FF);
    @(negedge clk);
    rst_n = 1'b1;
    wait_edges(1);
    chk(therm == 16'h00FF, "R1 therm after reset", therm, 16'h00FF);
    chk(locked == 1'b0, "R1 locked after reset", locked, 0);
    chk(fail == 1'b0, "R1 fail after reset", fail, 0);

    // R9: in window since reset, lock at band 8
    wait_edges(40);
    chk(locked == 1'b1, "R9 lock in window", locked, 1);

    // R3: short excursion below does not step; lock drops and returns
    drive(1'b1, 1'b0);
    wait_edges(1);
    drive(1'b0, 1'b0);
    wait_edges(4);
    chk(locked == 1'b0, "R3 glitch drops lock", locked, 0);
    wait_edges(60);
    chk(therm == 16'h00FF, "R3 glitch ignored", therm, 16'h00FF);
    chk(locked == 1'b1, "R9 relock after glitch", locked, 1);

    // R4/R5/R6/R7: below qualified, climb to 16 and saturate
    dwell_r = 12'd4;
    div_r = 8'd3;
    push_burst(8, 16, 4);
    drive(1'b1, 1'b0);
    wait_edges(120);
    chk(therm == 16'hFFFF, "R6 saturate high", therm, 16'hFFFF);
    chk(fail == 1'b1, "R7 fail at top", fail, 1);
    chk(exp_q.size() == 0, "R4 all up steps seen", exp_q.size(), 0);

    // R9: exact lock timing after entering window
    dwell_r = 12'd20;
    wait_edges(2);
    drive(1'b0, 1'b0);
    wait_edges(23);
    chk(locked == 1'b0, "R9 lock not early", locked, 0);
    chk(fail == 1'b0, "R7 fail clears in window", fail, 0);
    wait_edges(1);
    chk(locked == 1'b1, "R9 lock on time", locked, 1);

    // R4/R5/R6/R7: above qualified, descend to 0, longer step period
    dwell_r = 12'd4;
    div_r = 8'd6;
    push_burst(16, 0, 7);
    drive(1'b0, 1'b1);
    wait_edges(200);
    chk(therm == 16'h0000, "R6 saturate low", therm, 0);
    chk(fail == 1'b1, "R7 fail at bottom", fail, 1);
    chk(exp_q.size() == 0, "R4 all down steps seen", exp_q.size(), 0);

    // R10/R2: both flags set, no step, no lock, no fail
    drive(1'b1, 1'b1);
    wait_edges(100);
    chk(therm == 16'h0000, "R10 invalid pair holds band", therm, 0);
    chk(locked == 1'b0, "R10 invalid pair no lock", locked, 0);
    chk(fail == 1'b0, "R10 invalid pair no fail", fail, 0);

    // R9: relock at band 0 and stay frozen
    drive(1'b0, 1'b0);
    wait_edges(80);
    chk(locked == 1'b1, "R9 lock at band 0", locked, 1);
    chk(therm == 16'h0000, "R9 band frozen", therm, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule